// File: doc/BRIEF.md
# External Memory Read Cycle Sequencer

This block times one read access on an external memory bus. Time is counted in base periods. A single-clock `tick` pulse from a divider marks the edge of each base period. When the sequencer is idle, a start request arms it. The cycle then opens on the next tick and runs six phases, T1 to T6, in a fixed order. T1 and T6 each last one base period. The lengths of T2, T3, T4 and T5 come from 2-bit configuration fields.

A wait input can stretch the cycle after T4 by any number of extra base periods. The active-low read strobe covers T4, every wait period and T5. At the tick that closes T5, the data bus is captured into an output register and a one-clock capture pulse is raised. At the tick that closes T6, a one-clock done pulse is raised.

The block also exports signals for downstream strobe logic:
- one-hot phase flags;
- a wait-period flag;
- a base-period count that starts at T2.

Top module: `xmem_rd_seq`

## Requirements
- R1: After reset, `phase_oh` and `tm_count` are zero, `rd_strobe_n` is 1, and `busy`, `done`, `cap_pulse` and `wait_act` are 0.
- R2: A cycle visits T1, T2, T3, T4, T5 and T6 in that order. `phase_oh` bit 0 flags T1 and bit 5 flags T6, with at most one bit set. T1 and T6 each last exactly one base period.
- R3: T2 lasts `cfg_t2`+1 base periods and T3 lasts `cfg_t3`+1 base periods. Each field is an unsigned 2-bit value, so the range is 1 to 4.
- R4: T4 lasts `cfg_t4`+1 base periods and T5 lasts `cfg_t5`+1 base periods, with the same field encoding.
- R5: `wait_req` is sampled at the tick ending T4's last base period and at the tick ending each wait period. Each sample taken high adds one wait base period before T5. During a wait period `wait_act` is 1 and `phase_oh` is zero. The number of wait periods has no limit.
- R6: `rd_strobe_n` is 0 throughout T4, the wait periods and T5, and is 1 at all other times.
- R7: `rd_data_o` loads `rd_data_i` only on the clock edge that carries the tick ending T5. `cap_pulse` is high for the single clock after that edge. Bus values at any other time do not change `rd_data_o`.
- R8: A `start` seen while idle sets `busy` and arms the sequencer. T1 then begins at the next tick. A `start` seen during a cycle is ignored, so no further cycle follows.
- R9: `done` is high for the single clock after the tick ending T6. At that point the sequencer is idle.
- R10: `tm_count` is 0 in T1 and while idle. It is 0 in the first base period of T2 and increases by one per base period through T5 and T6, including wait periods. It saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock pulse marking each base period edge |
| start | input | 1 | Request a read cycle |
| cfg_t2 | input | LW | T2 length minus one, in base periods |
| cfg_t3 | input | LW | T3 length minus one |
| cfg_t4 | input | LW | T4 length minus one |
| cfg_t5 | input | LW | T5 length minus one |
| wait_req | input | 1 | Insert another wait period when high at a sample point |
| rd_data_i | input | DW | External data bus |
| rd_strobe_n | output | 1 | Active-low read strobe |
| cap_pulse | output | 1 | One clock after data capture |
| rd_data_o | output | DW | Captured read data |
| phase_oh | output | 6 | One-hot T1..T6 flags (bit 0 = T1) |
| wait_act | output | 1 | A wait period is in progress |
| tm_count | output | CW | Base periods elapsed since T2 began |
| busy | output | 1 | Armed or in a cycle |
| done | output | 1 | One clock after the end of T6 |

## Verification
Two corners are hard to reach from the ports. The first is a wait chain long enough to push `tm_count` into saturation. The bench holds `wait_req` high for 260 consecutive sample points, so the chain reaches saturation within one cycle.

The second is a start request landing mid-cycle. The bench inserts it between two ticks and then runs extra ticks after done, to show that no second cycle is armed.

The bench changes the data bus on every base period except at the capture point. This shows that only that one value reaches `rd_data_o`.

// File: rtl/xmem_rd_pkg.sv
`timescale 1ns/1ps
package xmem_rd_pkg;
    // Phase codes: T1..T6 are 1..6 so the one-hot decode is a plain index.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4,
        PH_T5   = 3'd5,
        PH_T6   = 3'd6,
        PH_WAIT = 3'd7
    } rd_phase_e;
endpackage

// File: rtl/xmem_rd_len_sel.sv
`timescale 1ns/1ps
module xmem_rd_len_sel
    import xmem_rd_pkg::*;
#(
    parameter int LW = 2
) (
    input  rd_phase_e         phase,
    input  logic [LW-1:0]     cfg_t2,
    input  logic [LW-1:0]     cfg_t3,
    input  logic [LW-1:0]     cfg_t4,
    input  logic [LW-1:0]     cfg_t5,
    output logic [LW-1:0]     last_idx
);
    // Index of the final base period within the current phase.
    always_comb begin
        case (phase)
            PH_T2:   last_idx = cfg_t2;
            PH_T3:   last_idx = cfg_t3;
            PH_T4:   last_idx = cfg_t4;
            PH_T5:   last_idx = cfg_t5;
            default: last_idx = '0;
        endcase
    end
endmodule

// File: rtl/xmem_rd_tm_cnt.sv
`timescale 1ns/1ps
module xmem_rd_tm_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && (cnt_q != {CW{1'b1}}))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/xmem_rd_seq.sv
`timescale 1ns/1ps
module xmem_rd_seq
    import xmem_rd_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 2,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [LW-1:0] cfg_t2,
    input  logic [LW-1:0] cfg_t3,
    input  logic [LW-1:0] cfg_t4,
    input  logic [LW-1:0] cfg_t5,
    input  logic          wait_req,
    input  logic [DW-1:0] rd_data_i,
    output logic          rd_strobe_n,
    output logic          cap_pulse,
    output logic [DW-1:0] rd_data_o,
    output logic [5:0]    phase_oh,
    output logic          wait_act,
    output logic [CW-1:0] tm_count,
    output logic          busy,
    output logic          done
);
    localparam int NPH = 6;

    typedef struct packed {
        rd_phase_e     phase;
        logic [LW-1:0] pcnt;
        logic          armed;
        logic          strobe_n;
        logic          cap;
        logic          done;
        logic [DW-1:0] data;
    } seq_st_t;

    seq_st_t       st_d, st_q;
    logic [LW-1:0] last_idx;
    logic          tm_clr, tm_inc;

    xmem_rd_len_sel #(.LW(LW)) u_len (
        .phase    (st_q.phase),
        .cfg_t2   (cfg_t2),
        .cfg_t3   (cfg_t3),
        .cfg_t4   (cfg_t4),
        .cfg_t5   (cfg_t5),
        .last_idx (last_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cap  = 1'b0;
        st_d.done = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (tick && st_q.armed) begin
                st_d.phase = PH_T1;
                st_d.armed = 1'b0;
                st_d.pcnt  = '0;
            end else if (start) begin
                st_d.armed = 1'b1;
            end
        end else if (tick) begin
            if (st_q.pcnt == last_idx) begin
                st_d.pcnt = '0;
                case (st_q.phase)
                    PH_T1:   st_d.phase = PH_T2;
                    PH_T2:   st_d.phase = PH_T3;
                    PH_T3:   st_d.phase = PH_T4;
                    PH_T4,
                    PH_WAIT: st_d.phase = wait_req ? PH_WAIT : PH_T5;
                    PH_T5: begin
                        st_d.phase = PH_T6;
                        st_d.cap   = 1'b1;
                        st_d.data  = rd_data_i;
                    end
                    PH_T6: begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                    default: st_d.phase = PH_IDLE;
                endcase
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
        end
        st_d.strobe_n = !(st_d.phase inside {PH_T4, PH_WAIT, PH_T5});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.strobe_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // Base-period count: cleared leaving T1 and T6, advanced through the rest.
    assign tm_clr = tick && (st_q.phase inside {PH_T1, PH_T6});
    assign tm_inc = tick && (st_q.phase inside {PH_T2, PH_T3, PH_T4, PH_WAIT, PH_T5});

    xmem_rd_tm_cnt #(.CW(CW)) u_tm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tm_clr),
        .inc   (tm_inc),
        .cnt   (tm_count)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_oh
        assign phase_oh[i] = (st_q.phase == rd_phase_e'(3'(i + 1)));
    end

    assign wait_act    = (st_q.phase == PH_WAIT);
    assign rd_strobe_n = st_q.strobe_n;
    assign cap_pulse   = st_q.cap;
    assign rd_data_o   = st_q.data;
    assign done        = st_q.done;
    assign busy        = st_q.armed || (st_q.phase != PH_IDLE);
endmodule

// File: rtl/xmem_rd_seq_chk.sv
`timescale 1ns/1ps
module xmem_rd_seq_chk #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          rd_strobe_n,
    input logic          cap_pulse,
    input logic [DW-1:0] rd_data_o,
    input logic [5:0]    phase_oh,
    input logic          wait_act,
    input logic [CW-1:0] tm_count,
    input logic          busy,
    input logic          done
);
    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_oh)); // R2
    AST_T1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_oh[0] && tick) |=> phase_oh[1]); // R2
    AST_WAIT_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        wait_act |-> (phase_oh == 6'b0)); // R5
    AST_STROBE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe_n) == (phase_oh[3] || phase_oh[4] || wait_act)); // R6
    AST_CAP_IN_T6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |-> phase_oh[5]); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |-> $stable(rd_data_o)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase_oh == 6'b0 && !wait_act)); // R9
    AST_TM_ZERO_T1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[0] |-> (tm_count == '0)); // R10
    AST_BUSY_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_oh != 6'b0) |-> busy); // R8
endmodule

bind xmem_rd_seq xmem_rd_seq_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/xmem_rd_seq_bench.sv
`timescale 1ns/1ps
module xmem_rd_seq_bench;
    localparam int DW = 16;
    localparam int LW = 2;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] cfg_t2 = '0, cfg_t3 = '0, cfg_t4 = '0, cfg_t5 = '0;
    logic          wait_req = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          rd_strobe_n, cap_pulse, wait_act, busy, done;
    logic [DW-1:0] rd_data_o;
    logic [5:0]    phase_oh;
    logic [CW-1:0] tm_count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xmem_rd_seq #(.DW(DW), .LW(LW), .CW(CW)) u_xmem_rd_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .cfg_t2(cfg_t2), .cfg_t3(cfg_t3), .cfg_t4(cfg_t4), .cfg_t5(cfg_t5),
        .wait_req(wait_req), .rd_data_i(rd_data_i),
        .rd_strobe_n(rd_strobe_n), .cap_pulse(cap_pulse), .rd_data_o(rd_data_o),
        .phase_oh(phase_oh), .wait_act(wait_act), .tm_count(tm_count),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One base period: tick is high across exactly one rising edge; sample just after.
    task automatic step();
        repeat (2) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic test_reset();
        chk(phase_oh == 6'b0, "R1 phase_oh", phase_oh, 0);
        chk(rd_strobe_n == 1'b1, "R1 strobe", rd_strobe_n, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(cap_pulse == 1'b0, "R1 cap", cap_pulse, 0);
        chk(wait_act == 1'b0, "R1 wait_act", wait_act, 0);
        chk(tm_count == '0, "R1 tm_count", tm_count, 0);
    endtask

    // Codes: 0..5 = T1..T6, 6 = wait period.
    task automatic run_cycle(input logic [1:0] a2, input logic [1:0] a3,
                             input logic [1:0] a4, input logic [1:0] a5,
                             input int nw, input logic [DW-1:0] dat, input bit mid_start);
        int exp_q[$];
        cfg_t2 = a2; cfg_t3 = a3; cfg_t4 = a4; cfg_t5 = a5;
        exp_q.push_back(0);
        for (int i = 0; i <= int'(a2); i++) exp_q.push_back(1);
        for (int i = 0; i <= int'(a3); i++) exp_q.push_back(2);
        for (int i = 0; i <= int'(a4); i++) exp_q.push_back(3);
        for (int i = 0; i < nw; i++)        exp_q.push_back(6);
        for (int i = 0; i <= int'(a5); i++) exp_q.push_back(4);
        exp_q.push_back(5);

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R8 armed busy", busy, 1);
        chk(phase_oh == 6'b0, "R8 waits for tick", phase_oh, 0);

        for (int k = 0; k < exp_q.size(); k++) begin
            int code;
            int exp_tm;
            logic [5:0] exp_oh;
            logic exp_sn;
            code = exp_q[k];
            wait_req = (code == 6);
            if (k > 0 && exp_q[k-1] == 4 && code == 5)
                rd_data_i = dat;
            else
                rd_data_i = ~dat ^ DW'(k);
            if (mid_start && k == 2) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            step();
            exp_oh = (code < 6) ? (6'b1 << code) : 6'b0;
            exp_sn = !(code == 3 || code == 4 || code == 6);
            exp_tm = (k == 0) ? 0 : ((k - 1) > 255 ? 255 : (k - 1));
            // R2 R3 R4 R5: phase order and lengths
            chk(phase_oh == exp_oh, "R2/R3/R4 phase", phase_oh, exp_oh);
            chk(wait_act == (code == 6), "R5 wait_act", wait_act, code == 6);
            chk(rd_strobe_n == exp_sn, "R6 strobe", rd_strobe_n, exp_sn);
            chk(tm_count == CW'(exp_tm), "R10 tm_count", tm_count, exp_tm);
            chk(cap_pulse == (code == 5), "R7 cap_pulse", cap_pulse, code == 5);
            chk(done == 1'b0, "R9 no early done", done, 0);
            if (code == 5)
                chk(rd_data_o == dat, "R7 captured data", rd_data_o, dat);
        end

        wait_req = 1'b0;
        rd_data_i = 16'hDEAD;
        step();
        chk(done == 1'b1, "R9 done", done, 1);
        chk(phase_oh == 6'b0, "R9 idle", phase_oh, 0);
        chk(rd_strobe_n == 1'b1, "R6 strobe idle", rd_strobe_n, 1);
        chk(tm_count == '0, "R10 cleared", tm_count, 0);
        chk(rd_data_o == dat, "R7 bus ignored", rd_data_o, dat);
        rd_data_i = 16'hBEEF;
        step();
        chk(done == 1'b0, "R9 done one clock", done, 0);
        if (mid_start) begin
            step();
            chk(phase_oh == 6'b0, "R8 no second cycle", phase_oh, 0);
            chk(busy == 1'b0, "R8 not rearmed", busy, 0);
        end
        chk(rd_data_o == dat, "R7 held", rd_data_o, dat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_cycle(2'd0, 2'd0, 2'd0, 2'd0, 0, 16'h1234, 1'b0); // R3 R4 minimum
        run_cycle(2'd3, 2'd3, 2'd3, 2'd3, 0, 16'hA5C3, 1'b0); // R3 R4 maximum
        run_cycle(2'd1, 2'd2, 2'd0, 2'd3, 3, 16'h0F0F, 1'b1); // R5 R8
        run_cycle(2'd0, 2'd1, 2'd2, 2'd0, 260, 16'h7E81, 1'b0); // R10 saturation
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule